// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside the command sequencer of an SDR SDRAM controller and produces the column address that goes with each beat of a read or write burst. A mode word is latched when a mode load is issued. Bits 2..0 of that word select the burst length and bit 3 selects the ordering, where 0 means a sequential wrap and 1 means an XOR interleave. Bit 9 forces every write burst down to a single beat.

A start request carries a start column and a read/write flag. From the following cycle the block presents one column per cycle and raises an active flag for the whole burst. It also marks the final beat of a burst that has a fixed length. A full-page burst never ends by itself. It wraps around the row and keeps going until a burst-stop or a new start request arrives. A precharge ends a burst in the same way as a burst-stop, so the sequencer signals it through the stop input.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, colValid, lastBeat, modeErr and colAddr are all 0, and the mode is a one-beat sequential burst with single-beat writes off.
- R2: A mode load latches modeWord. Length codes in bits 2..0 map as follows: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8, and 111 gives a full page of 256 beats.
- R3: With bit 3 at 0 (sequential), the column offset inside the aligned block of the burst length counts up and wraps. Column bits above the block stay at the start value. For example, start 0x2D with length 8 gives 2D,2E,2F,28,29,2A,2B,2C.
- R4: With bit 3 at 1 (interleave), beat i uses the start offset XOR i inside the block. For example, start 0x2D with length 8 gives 2D,2C,2F,2E,29,28,2B,2A.
- R5: Beat 0 (the start column) appears the cycle after startReq, with one beat per cycle after that. lastBeat is high only on the final beat, and colValid is low the cycle after the final beat unless a new start arrives.
- R6: A full-page burst never raises lastBeat. It wraps from column 255 to 0 and keeps running until it is stopped or restarted.
- R7: A stopReq seen during a burst makes the current beat the last one, so colValid is low from the next cycle. This works at any length. A stopReq while idle has no effect.
- R8: When bit 9 is 1, a write burst is exactly one beat with lastBeat high, whatever the length code. Read bursts keep the programmed length.
- R9: A startReq during any beat, including the final one, begins the new burst on the next cycle with no idle gap. If startReq and stopReq arrive in the same cycle, the start wins.
- R10: A reserved length code (100, 101, 110), or code 111 together with interleave, behaves as length 1 and sets modeErr. modeErr stays set until a valid mode is loaded.
- R11: A mode load during a burst does not change the burst in progress. It applies to later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| modeLoad | input | 1 | Latch modeWord this cycle |
| modeWord | input | MODE_W | Mode word: length code [2:0], interleave [3], single-beat writes [9] |
| startReq | input | 1 | Begin a burst at startCol |
| startIsWrite | input | 1 | The burst being started is a write |
| startCol | input | COL_W | Start column of the burst |
| stopReq | input | 1 | Terminate the running burst after the current beat |
| colAddr | output | COL_W | Column of the current beat, 0 when idle |
| colValid | output | 1 | A burst beat is being presented |
| lastBeat | output | 1 | The current beat is the final one |
| modeErr | output | 1 | The latched mode uses a reserved combination |

## Verification
Each fixed length is tried with start columns whose offsets are misaligned inside the block and whose upper bits are non-zero. This separates a true wrap inside the block from a plain count up the row, and it also catches any disturbance of the upper column bits. The same starts are repeated with interleaving, where offsets 3 and 5 produce orders that differ from the sequential ones. A 300-beat full-page read checks the wrap past column 255 and confirms that lastBeat never rises. Stop, restart on the last beat, simultaneous start and stop, a mode reload during a burst, single-beat writes next to full-length reads, and the reserved codes each get their own sequence.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;

  // Strobes sent from the control to the datapath each cycle
  typedef struct packed {
    logic loadStart;  // capture start column and ordering, zero the beat index
    logic advance;    // move to the next beat
  } dpStrobe_t;

  // Mode word field positions
  localparam int LEN_LSB   = 0;
  localparam int LEN_MSB   = 2;
  localparam int TYPE_BIT  = 3;
  localparam int SWR_BIT   = 9;

  // Length code values
  localparam logic [2:0] LEN_FULL = 3'b111;

endpackage

// File: rtl/burst_mode_reg.sv
module burst_mode_reg
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeWord,
  output logic [COL_W-1:0]  modeMask,
  output logic              modeFull,
  output logic              modeIlv,
  output logic              modeSingleWr,
  output logic              modeErr
);

  logic [2:0]       lenCode;
  logic             ilvBit;
  logic [COL_W-1:0] decMask;
  logic             decFull;
  logic             decErr;

  // Bits with no meaning to this block
  logic unusedModeBits;
  assign unusedModeBits = ^{modeWord[MODE_W-1:SWR_BIT+1], modeWord[SWR_BIT-1:TYPE_BIT+1]};

  assign lenCode = modeWord[LEN_MSB:LEN_LSB];
  assign ilvBit  = modeWord[TYPE_BIT];

  always_comb begin
    decMask = '0;
    decFull = 1'b0;
    decErr  = 1'b0;
    case (lenCode)
      3'd0, 3'd1, 3'd2, 3'd3: decMask = (COL_W'(1) << lenCode) - COL_W'(1);
      LEN_FULL: begin
        if (ilvBit) begin
          decErr = 1'b1;
        end else begin
          decMask = '1;
          decFull = 1'b1;
        end
      end
      default: decErr = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeMask     <= '0;
      modeFull     <= 1'b0;
      modeIlv      <= 1'b0;
      modeSingleWr <= 1'b0;
      modeErr      <= 1'b0;
    end else if (modeLoad) begin
      modeMask     <= decMask;
      modeFull     <= decFull;
      modeIlv      <= ilvBit;
      modeSingleWr <= modeWord[SWR_BIT];
      modeErr      <= decErr;
    end
  end

endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             startIsWrite,
  input  logic             stopReq,
  input  logic [COL_W-1:0] modeMask,
  input  logic             modeFull,
  input  logic             modeSingleWr,
  output dpStrobe_t        strobe,
  output logic [COL_W-1:0] burstMask,
  output logic             active,
  output logic             lastBeat
);

  logic [COL_W-1:0] beatsLeft;
  logic             fullRun;
  logic             shortWrite;
  logic [COL_W-1:0] effMask;
  logic             effFull;

  assign shortWrite = startIsWrite & modeSingleWr;
  assign effMask    = shortWrite ? '0 : modeMask;
  assign effFull    = ~shortWrite & modeFull;

  assign lastBeat         = active & ~fullRun & (beatsLeft == '0);
  assign strobe.loadStart = startReq;
  assign strobe.advance   = active & ~startReq & ~stopReq & ~lastBeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      fullRun   <= 1'b0;
      burstMask <= '0;
      beatsLeft <= '0;
    end else if (startReq) begin
      active    <= 1'b1;
      fullRun   <= effFull;
      burstMask <= effMask;
      beatsLeft <= effMask;
    end else if (active && (stopReq || lastBeat)) begin
      active    <= 1'b0;
    end else if (strobe.advance && !fullRun) begin
      beatsLeft <= beatsLeft - COL_W'(1);
    end
  end

endmodule

// File: rtl/burst_addr_dp.sv
module burst_addr_dp
  import burst_col_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic             modeIlv,
  input  logic [COL_W-1:0] burstMask,
  output logic [COL_W-1:0] beatCol
);

  logic [COL_W-1:0] baseR;
  logic [COL_W-1:0] beatIdx;
  logic             ilvR;
  logic [COL_W-1:0] offCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseR   <= '0;
      beatIdx <= '0;
      ilvR    <= 1'b0;
    end else if (strobe.loadStart) begin
      baseR   <= startCol;
      beatIdx <= '0;
      ilvR    <= modeIlv;
    end else if (strobe.advance) begin
      beatIdx <= beatIdx + COL_W'(1);
    end
  end

  // The carry out of the block is cut by the per-bit select below
  assign offCol = ilvR ? (baseR ^ beatIdx) : (baseR + beatIdx);

  for (genvar b = 0; b < COL_W; b++) begin : g_colBit
    assign beatCol[b] = burstMask[b] ? offCol[b] : baseR[b];
  end

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeLoad,
  input  logic [MODE_W-1:0] modeWord,
  input  logic              startReq,
  input  logic              startIsWrite,
  input  logic [COL_W-1:0]  startCol,
  input  logic              stopReq,
  output logic [COL_W-1:0]  colAddr,
  output logic              colValid,
  output logic              lastBeat,
  output logic              modeErr
);

  logic [COL_W-1:0] modeMask;
  logic             modeFull;
  logic             modeIlv;
  logic             modeSingleWr;
  dpStrobe_t        strobe;
  logic [COL_W-1:0] burstMask;
  logic [COL_W-1:0] beatCol;

  burst_mode_reg #(.COL_W(COL_W), .MODE_W(MODE_W)) u_mode (
    .clk(clk), .rstN(rstN), .modeLoad(modeLoad), .modeWord(modeWord),
    .modeMask(modeMask), .modeFull(modeFull), .modeIlv(modeIlv),
    .modeSingleWr(modeSingleWr), .modeErr(modeErr)
  );

  burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startIsWrite(startIsWrite),
    .stopReq(stopReq), .modeMask(modeMask), .modeFull(modeFull),
    .modeSingleWr(modeSingleWr), .strobe(strobe), .burstMask(burstMask),
    .active(colValid), .lastBeat(lastBeat)
  );

  burst_addr_dp #(.COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startCol(startCol),
    .modeIlv(modeIlv), .burstMask(burstMask), .beatCol(beatCol)
  );

  assign colAddr = colValid ? beatCol : '0;

endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [COL_W-1:0] startCol,
  input logic             stopReq,
  input logic [COL_W-1:0] colAddr,
  input logic             colValid,
  input logic             lastBeat,
  input logic [COL_W-1:0] burstMask
);

  a_r5_first_beat: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> (colValid && colAddr == $past(startCol)));

  a_r5_ends_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (lastBeat && !startReq) |=> !colValid);

  a_r7_stop_ends: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && stopReq && !startReq) |=> !colValid);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !colValid |-> (!lastBeat && colAddr == '0));

  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (colValid && $past(colValid) && !$past(startReq))
      |-> (((colAddr ^ $past(colAddr)) & ~burstMask) == '0));

endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_gen_tb.sv
module burst_col_gen_tb;
  localparam int COL_W  = 8;
  localparam int MODE_W = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              modeLoad = 1'b0;
  logic [MODE_W-1:0] modeWord = '0;
  logic              startReq = 1'b0;
  logic              startIsWrite = 1'b0;
  logic [COL_W-1:0]  startCol = '0;
  logic              stopReq = 1'b0;
  logic [COL_W-1:0]  colAddr;
  logic              colValid;
  logic              lastBeat;
  logic              modeErr;

  always #5 clk = ~clk;

  burst_col_gen #(.COL_W(COL_W), .MODE_W(MODE_W)) u_dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference mode state
  int mLen = 1;
  bit mIlv = 0, mSw = 0, mFull = 0, mErr = 0;

  logic [COL_W:0] expQ[$];
  string          tagQ[$];

  task automatic checkVal(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    checkVal({tag, " colValid"}, int'(colValid), 0);
    checkVal({tag, " lastBeat"}, int'(lastBeat), 0);
    checkVal({tag, " colAddr"}, int'(colAddr), 0);
  endtask

  task automatic pushBurst(input int col, input bit wr, input int n, input string tag);
    int len, off, blk, o;
    bit full;
    len  = (wr && mSw) ? 1 : mLen;
    full = !(wr && mSw) && mFull;
    off  = col % len;
    blk  = col - off;
    for (int i = 0; i < n; i++) begin
      o = mIlv ? (off ^ i) : ((off + i) % len);
      expQ.push_back({(!full && i == len - 1), COL_W'(blk + o)});
      tagQ.push_back(tag);
    end
  endtask

  // Called at a falling edge; returns one cycle later with beat 0 visible
  task automatic startB(input int col, input bit wr, input int n, input bit withStop,
                        input string tag);
    pushBurst(col, wr, n, tag);
    startReq = 1'b1; startCol = COL_W'(col); startIsWrite = wr; stopReq = withStop;
    @(negedge clk);
    startReq = 1'b0; stopReq = 1'b0; startIsWrite = 1'b0;
  endtask

  task automatic stopB();
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setMode(input int code, input bit ilv, input bit sw);
    modeWord = '0;
    modeWord[2:0] = 3'(code);
    modeWord[3] = ilv;
    modeWord[9] = sw;
    modeWord[6] = 1'b1;  // meaningless bit, must be ignored
    modeLoad = 1'b1;
    @(negedge clk);
    modeLoad = 1'b0;
    mErr  = (code >= 4 && code <= 6) || (code == 7 && ilv);
    mFull = !mErr && code == 7;
    mLen  = mErr ? 1 : (code == 7 ? 256 : (1 << code));
    mIlv  = ilv;
    mSw   = sw;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && colValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected beat actual=%0h expected=none", colAddr);
      end else begin
        logic [COL_W:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if ({lastBeat, colAddr} != e) begin
          errors++;
          $display("FAIL %s beat actual last=%0d col=%0h expected last=%0d col=%0h",
                   t, lastBeat, colAddr, e[COL_W], e[COL_W-1:0]);
        end
      end
    end
  end

  initial begin
    #100us;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    // R1 reset state
    checkIdle("R1");
    checkVal("R1 modeErr", int'(modeErr), 0);

    // R1/R2 default one-beat burst
    startB(8'h13, 0, 1, 0, "R1 default len");
    waitCyc(1); checkIdle("R5 after len1");

    // R2/R3 sequential lengths
    setMode(1, 0, 0);
    startB(8'h41, 0, 2, 0, "R2 len2");
    waitCyc(2); checkIdle("R5 after len2");
    setMode(2, 0, 0);
    startB(8'h86, 0, 4, 0, "R2 len4");
    waitCyc(4); checkIdle("R5 after len4");
    setMode(3, 0, 0);
    startB(8'h2D, 0, 8, 0, "R3 seq len8");
    waitCyc(8); checkIdle("R5 after len8");

    // R4 interleave
    setMode(2, 1, 0);
    startB(8'h87, 0, 4, 0, "R4 ilv len4");
    waitCyc(4);
    setMode(3, 1, 0);
    startB(8'h2D, 0, 8, 0, "R4 ilv len8");
    waitCyc(8); checkIdle("R4 after");

    // R6/R7 full page, stop
    setMode(7, 0, 0);
    checkVal("R2 full mode no err", int'(modeErr), 0);
    startB(8'hFD, 0, 6, 0, "R6 full wrap");
    waitCyc(5); stopB();
    checkIdle("R7 after stop");
    startB(8'h10, 0, 300, 0, "R6 full long");
    waitCyc(299); stopB();
    checkIdle("R6 after long stop");
    stopB();
    checkIdle("R7 stop while idle");

    // R8 single-beat writes
    setMode(3, 0, 1);
    startB(8'h12, 1, 1, 0, "R8 write single");
    waitCyc(1); checkIdle("R8 after write");
    startB(8'h12, 0, 8, 0, "R8 read full len");
    waitCyc(8);
    setMode(7, 0, 1);
    startB(8'h55, 1, 1, 0, "R8 write single fullpage");
    waitCyc(1); checkIdle("R8 after fp write");

    // R9 restart on last beat, start beats stop
    setMode(2, 0, 0);
    startB(8'h04, 0, 4, 0, "R9 first");
    waitCyc(3);
    startB(8'h30, 0, 4, 0, "R9 back to back");
    waitCyc(4); checkIdle("R9 after b2b");
    startB(8'h08, 0, 2, 0, "R9 cut");
    waitCyc(1);
    startB(8'h61, 0, 4, 1, "R9 start wins over stop");
    waitCyc(4); checkIdle("R9 after");

    // R11 mode reload mid-burst
    setMode(3, 0, 0);
    startB(8'h1B, 0, 8, 0, "R11 running burst");
    waitCyc(1);
    setMode(1, 0, 0);
    waitCyc(6); checkIdle("R11 after");
    startB(8'h19, 0, 2, 0, "R11 new mode applies");
    waitCyc(2);

    // R10 reserved codes
    setMode(5, 0, 0);
    checkVal("R10 reserved err", int'(modeErr), 1);
    startB(8'h77, 0, 1, 0, "R10 reserved len1");
    waitCyc(1); checkIdle("R10 after");
    setMode(7, 1, 0);
    checkVal("R10 fullpage ilv err", int'(modeErr), 1);
    startB(8'h3C, 0, 1, 0, "R10 fp ilv len1");
    waitCyc(1);
    setMode(2, 1, 0);
    checkVal("R10 err cleared", int'(modeErr), 0);

    waitCyc(2);
    checkVal("R5 all beats seen", expQ.size(), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule